// File: doc/BRIEF.md
# Bus Read Cycle Controller

This block sits between a processor core and a slow memory and runs one read at a time. The core offers an address on a valid/ready handshake. Once the controller takes it, the controller drives that address onto the memory address bus. It then pulls an active-low read strobe and keeps the strobe low for a configurable number of wait cycles, which gives the memory time to answer. When the strobe is released, the value on the memory data bus is latched. The latched value is handed back to the core with a one-cycle completion pulse.

Each read runs through fixed phases: address setup, strobe assertion, wait, and release. With the default single wait cycle, a read occupies four clock cycles. The memory gives no ready or acknowledge signal of its own. The data is taken as valid at the moment the strobe rises. The ready output doubles as the busy indication. While it is low, request inputs are ignored. They are neither queued nor remembered.

Top module: `bus_read_ctrl`

## Requirements
- R1: While reset is high and after it is released, the strobe `mem_rd_n` is 1, `req_ready` is 1, `rsp_done` is 0, and both `mem_addr` and `rsp_data` are 0.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. In the following cycle `mem_addr` equals the taken address, `mem_rd_n` is still 1, and `req_ready` is 0.
- R3: The strobe `mem_rd_n` is 0 for exactly 1+WAIT_CYCLES consecutive cycles. These cycles start in the cycle after the address cycle.
- R4: `mem_addr` does not change from the address cycle until the cycle in which the data is latched. When idle, `mem_addr` keeps the last address.
- R5: `rsp_data` takes the value that `mem_data` had in the last strobe-low cycle, on the same edge where `mem_rd_n` returns to 1. The value of `mem_data` in any other cycle has no effect on `rsp_data`.
- R6: `rsp_done` is 1 for exactly one cycle per read. That cycle is the first cycle with `mem_rd_n` back at 1.
- R7: `req_ready` is 0 in every cycle of a read, including the release cycle. A request raised while `req_ready` is 0 is dropped and never starts a read.
- R8: A read lasts 3+WAIT_CYCLES cycles, which is 4 with the default WAIT_CYCLES=1. With `req_valid` held high, the next request is taken in the first idle cycle after the release cycle.
- R9: `rsp_data` holds its value between reads, whatever `mem_data` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a read request |
| req_addr | input | ADDR_W | Address of the offered read |
| req_ready | output | 1 | High when idle and able to take a request; low means busy |
| rsp_done | output | 1 | One-cycle pulse when read data is available |
| rsp_data | output | DATA_W | Latched read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_rd_n | output | 1 | Read strobe to memory, active low |
| mem_data | input | DATA_W | Memory data bus |

## Verification
Two situations can land in the same cycle. The first is the completion pulse together with a fresh request from the core. The bench raises `req_valid` for one cycle exactly in the release cycle, where `rsp_done` is 1. That request must be dropped: `req_ready` and `mem_addr` stay at their idle values afterwards. The second is the latch of data together with the strobe's rising edge. The bench's memory drives the true word only while the strobe is low and a complemented word otherwise. A latch taken one edge early or one edge late therefore shows up as a wrong `rsp_data`. A behavioural model of the phases is compared against every output on every clock, under back-to-back, isolated and mid-read requests.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_STRB = 3'd2,
        PH_WAIT = 3'd3,
        PH_REL  = 3'd4
    } rd_phase_e;

    // strobe is asserted (low on the pin) during these phases
    function automatic logic strobe_active(input rd_phase_e ph);
        return (ph == PH_STRB) || (ph == PH_WAIT);
    endfunction

    function automatic logic phase_busy(input rd_phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/rdc_sequencer.sv
module rdc_sequencer
    import rdc_pkg::*;
#(
    parameter int WAIT_CYCLES = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output rd_phase_e phase,
    output logic      capture
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;

    rd_phase_e       phase_q;
    rd_phase_e       phase_d;
    logic [CW-1:0]   cnt_q;
    logic            wait_last;

    assign wait_last = (cnt_q == CW'(WAIT_CYCLES - 1));

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start) phase_d = PH_ADDR;
            PH_ADDR: phase_d = PH_STRB;
            PH_STRB: phase_d = PH_WAIT;
            PH_WAIT: if (wait_last) phase_d = PH_REL;
            PH_REL:  phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_WAIT && !wait_last)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    assign phase   = phase_q;
    assign capture = (phase_q == PH_WAIT) && wait_last;

endmodule

// File: rtl/rdc_addr_reg.sv
module rdc_addr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    always_ff @(posedge clk) begin
        if (rst)       addr_out <= '0;
        else if (load) addr_out <= addr_in;
    end
endmodule

// File: rtl/rdc_capture_reg.sv
module rdc_capture_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grab,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (grab) held <= bus_in;
    end
endmodule

// File: rtl/bus_read_ctrl.sv
module bus_read_ctrl
    import rdc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int WAIT_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_data
);
    rd_phase_e phase;
    logic      capture;
    logic      start;

    assign req_ready = !phase_busy(phase);
    assign start     = req_valid && req_ready;

    rdc_sequencer #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phase   (phase),
        .capture (capture)
    );

    rdc_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .addr_in  (req_addr),
        .addr_out (mem_addr)
    );

    rdc_capture_reg #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .grab   (capture),
        .bus_in (mem_data),
        .held   (rsp_data)
    );

    assign mem_rd_n = !strobe_active(phase);
    assign rsp_done = (phase == PH_REL);

endmodule

// File: rtl/bus_read_ctrl_chk.sv
module bus_read_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_n,
    input logic [DATA_W-1:0] mem_data
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (mem_rd_n && req_ready && !rsp_done));

    assert_take_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && mem_rd_n && mem_addr == $past(req_addr)));

    assert_strobe_after_addr_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(mem_rd_n) |-> ($past(!req_ready) && $stable(mem_addr)));

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        rsp_done |-> (rsp_data == $past(mem_data)));

    assert_done_edge_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        rsp_done |-> (mem_rd_n && $past(!mem_rd_n)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_rd_n && !rsp_done));

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        (!rsp_done && req_ready) |-> $stable(rsp_data));

endmodule

bind bus_read_ctrl bus_read_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data),
    .mem_addr  (mem_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_data  (mem_data)
);

// File: tb/test_bus_read_ctrl.sv
module test_bus_read_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int W  = 1;
    localparam int LAST = 3 + W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_done;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_n;
    logic [DW-1:0] mem_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic seen_edge = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory: true word only while strobe is low
    assign mem_data = mem_rd_n ? ~word_of(mem_addr) : word_of(mem_addr);

    bus_read_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(W)) i_bus_read_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
    );

    // behavioural reference
    int            m_phase = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (rst) begin
            m_phase <= 0; m_addr <= '0; m_data <= '0;
        end else if (m_phase == 0) begin
            if (req_valid) begin
                m_phase <= 1; m_addr <= req_addr;
            end
        end else begin
            if (m_phase == LAST - 1) m_data <= word_of(m_addr);
            m_phase <= (m_phase == LAST) ? 0 : m_phase + 1;
        end
    end

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (seen_edge) begin
            cmp(rst ? "R1" : "R7", "req_ready", 32'(req_ready), 32'(m_phase == 0));
            cmp(rst ? "R1" : "R3", "mem_rd_n", 32'(mem_rd_n), 32'(!(m_phase >= 2 && m_phase <= 2 + W)));
            cmp(rst ? "R1" : "R6", "rsp_done", 32'(rsp_done), 32'(m_phase == LAST));
            cmp(rst ? "R1" : "R4", "mem_addr", 32'(mem_addr), 32'(m_addr));
            cmp(rst ? "R1" : "R5", "rsp_data", 32'(rsp_data), 32'(m_data));
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic one_read(input logic [AW-1:0] a);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        cmp("R2", "addr after accept", 32'(mem_addr), 32'(a));
        cmp("R2", "strobe high in addr cycle", 32'(mem_rd_n), 32'd1);
        n = 1;
        while (!rsp_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        cmp("R8", "read length", 32'(n), 32'(LAST));
        cmp("R5", "latched word", 32'(rsp_data), 32'(word_of(a)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // isolated reads, corner addresses
        one_read(16'h0000);
        one_read(16'hFFFF);
        one_read(16'h1234);
        // R9: data holds across idle while bus shows garbage
        repeat (4) @(negedge clk);
        cmp("R9", "held data", 32'(rsp_data), 32'(word_of(16'h1234)));
        // R8: back-to-back with valid held high
        @(negedge clk);
        req_valid = 1'b1;
        for (int i = 0; i < 14; i++) begin
            req_addr = 16'hA500 + 16'(i);
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        // R7: request pulsed mid-read is dropped
        one_read(16'h0F0F);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h2222;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R7: request in the release (done) cycle is dropped
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h3C3C;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        cmp("R7", "ready after release", 32'(req_ready), 32'd1);
        repeat (3) @(negedge clk);
        cmp("R7", "dropped addr not driven", 32'(mem_addr), 32'h3C3C);
        cmp("R7", "still idle", 32'(req_ready), 32'd1);
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule